// File: doc/BRIEF.md
# Audio Sample FIFO Register and Interrupt Controller

This block sits between a processor's simple 32-bit register bus and the transmit side of an audio serial port. Software writes audio words into a sample FIFO through a write-only data port. Each stereo frame goes in as two words, left first and then right. The serializer drains the FIFO through a ready/valid port. The serializer also reads its operating fields from the block's outputs: transmit enable, the left flag, the clock ratio, the sample resolution and the channel field.

The block watches FIFO occupancy on every cycle. It raises an underrun condition when the FIFO is empty. It raises a level condition when occupancy falls below a trigger threshold, which is the FIFO depth shifted right by a 4-bit level code. Each condition sets a sticky status bit, and software clears a bit by writing a one to it. A single interrupt line is driven when the global interrupt enable is set and a status bit is both set and unmasked.

The bus addresses words. Word 0 holds the version, word 1 the configuration, word 2 the interrupt mask and word 3 the interrupt status. Words 4 to 7 are aliases of the sample data port.

Top module: `afc_ctrl`

## Requirements
- R1: Word 0 reads the VERSION parameter, and a write to word 0 has no effect. Reads of words 4 to 7 return 0, because the data port is write-only.
- R2: The configuration register (word 1) stores and reads back the following fields. Bit 0 is transmit enable and bit 1 is interrupt enable. Bit 2 is the left flag. Bits 15:8 are the clock ratio and bits 21:16 are the sample resolution. Bits 27:24 are the level code and bits 31:28 are the channel field. All other bits read 0, so writing all ones reads back 0xFF3FFF07.
- R3: The interrupt mask (word 2) keeps only bit 0 (underrun) and bit 1 (level). All other bits read 0.
- R4: Every write to words 4 to 7 pushes the write data into the FIFO. `smp_valid` is high whenever the FIFO is not empty. `smp_data` presents the words in the order they were written, and the word advances on each cycle where `smp_valid` and `smp_ready` are both high.
- R5: Status (word 3) bit 0 is underrun and bit 1 is level. A bit set by its condition stays set. A write with a one in a bit clears that bit at that edge, so a read in the next cycle returns 0 for it. The bit is set again one cycle later if its condition still holds.
- R6: The underrun condition is FIFO empty. The level condition is occupancy less than DEPTH >> level code. For example, code 2 with DEPTH 16 gives a threshold of 4. A code that shifts the threshold to 0 never sets the level condition.
- R7: A data write while the FIFO holds DEPTH words is dropped, and the stored words are unchanged.
- R8: `irq` is high exactly when interrupt enable is set and (status AND mask) is non-zero.
- R9: After reset the configuration, mask, status and read data are 0, and `irq` and `smp_valid` are low.
- R10: The configuration fields drive the `cfg_*` outputs directly.
- R11: Read data is registered. It appears on `bus_rdata` in the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| smp_valid | output | 1 | FIFO holds a sample word |
| smp_ready | input | 1 | Serializer takes the word |
| smp_data | output | 32 | Oldest FIFO word |
| irq | output | 1 | Interrupt request |
| cfg_tx_en | output | 1 | Transmit enable |
| cfg_left | output | 1 | Left flag |
| cfg_ratio | output | 8 | Clock ratio |
| cfg_res | output | 6 | Sample resolution |
| cfg_chan | output | 4 | Channel field |

## Verification
On every cycle, the assertions check the following properties:
- the occupancy bound and the drop of writes to a full FIFO;
- the occupancy step on a pop;
- that a cleared status bit is low after the clearing edge and that underrun re-sets itself on an empty FIFO;
- that configuration and mask hold when not written.

Some behaviour can only be shown by the bench's scenarios:
- the exact read-back values and word order;
- that the 0 read just after a clear turns into a re-set bit;
- the threshold crossing at a given level code;
- the interrupt gating.

// File: rtl/afc_pkg.sv
// Shared definitions for the audio FIFO controller: word map and config layout.
package afc_pkg;
    localparam int WORD_W = 32;
    localparam int ST_W   = 2;

    localparam logic [2:0] W_VERSION = 3'd0;
    localparam logic [2:0] W_CONFIG  = 3'd1;
    localparam logic [2:0] W_MASK    = 3'd2;
    localparam logic [2:0] W_STATUS  = 3'd3;

    localparam int ST_UNDER = 0;
    localparam int ST_LEVEL = 1;

    typedef struct packed {
        logic [3:0] chan;
        logic [3:0] lvl;
        logic [5:0] res;
        logic [7:0] ratio;
        logic       left;
        logic       irq_en;
        logic       tx_en;
    } cfg_t;

    // Place the stored fields at their bus bit positions; unimplemented bits read 0.
    function automatic logic [WORD_W-1:0] cfg_to_word(cfg_t c);
        return {c.chan, c.lvl, 2'b00, c.res, c.ratio, 5'b00000, c.left, c.irq_en, c.tx_en};
    endfunction
endpackage

// File: rtl/afc_regs.sv
// Register file and bus decode.
// Assumes single-cycle bus accesses; read data is registered and held between reads.
module afc_regs
    import afc_pkg::*;
#(
    parameter logic [WORD_W-1:0] VERSION = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [2:0]        bus_word,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [ST_W-1:0]   status_i,
    output cfg_t              cfg_o,
    output logic [ST_W-1:0]   mask_o,
    output logic [ST_W-1:0]   clr_o,
    output logic              push_o,
    output logic [WORD_W-1:0] push_data_o
);
    logic wr_en, rd_en;
    logic [WORD_W-1:0] rd_mux;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    // Configuration register: capture implemented fields on a write to word 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o <= '0;
        end else if (wr_en && bus_word == W_CONFIG) begin
            cfg_o.chan   <= bus_wdata[31:28];
            cfg_o.lvl    <= bus_wdata[27:24];
            cfg_o.res    <= bus_wdata[21:16];
            cfg_o.ratio  <= bus_wdata[15:8];
            cfg_o.left   <= bus_wdata[2];
            cfg_o.irq_en <= bus_wdata[1];
            cfg_o.tx_en  <= bus_wdata[0];
        end
    end

    // Interrupt mask register: two bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_o <= '0;
        else if (wr_en && bus_word == W_MASK)
            mask_o <= bus_wdata[ST_W-1:0];
    end

    // Write-one-to-clear strobes and FIFO push decode.
    always_comb begin
        clr_o       = (wr_en && bus_word == W_STATUS) ? bus_wdata[ST_W-1:0] : '0;
        push_o      = wr_en && bus_word[2];
        push_data_o = bus_wdata;
    end

    // Read multiplexer; the data-port words read as zero.
    always_comb begin
        case (bus_word)
            W_VERSION: rd_mux = VERSION;
            W_CONFIG:  rd_mux = cfg_to_word(cfg_o);
            W_MASK:    rd_mux = {{(WORD_W-ST_W){1'b0}}, mask_o};
            W_STATUS:  rd_mux = {{(WORD_W-ST_W){1'b0}}, status_i};
            default:   rd_mux = '0;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd_en)
            bus_rdata <= rd_mux;
    end

    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && bus_word == W_CONFIG) |=> $stable(cfg_o));
    a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && bus_word == W_MASK) |=> $stable(mask_o));
endmodule

// File: rtl/afc_fifo.sv
// Sample FIFO with a first-word-fall-through pop port.
// Assumes DEPTH is a power of two. A push into a full FIFO is dropped.
module afc_fifo #(
    parameter int DEPTH = 1024,
    parameter int W     = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [W-1:0]     push_data_i,
    output logic             valid_o,
    input  logic             ready_i,
    output logic [W-1:0]     data_o,
    output logic [CNT_W-1:0] count_o
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, do_push, do_pop;

    assign full    = (count_o == CNT_W'(DEPTH));
    assign valid_o = (count_o != '0);
    assign do_push = push_i && !full;
    assign do_pop  = valid_o && ready_i;
    assign data_o  = mem[rd_ptr];

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= push_data_i;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_o <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count_o <= count_o + 1'b1;
                2'b01:   count_o <= count_o - 1'b1;
                default: count_o <= count_o;
            endcase
        end
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(DEPTH));
    a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full && !ready_i) |=> $stable(count_o));
    a_r4_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && !push_i) |=> count_o == $past(count_o) - 1'b1);
endmodule

// File: rtl/afc_status.sv
// Sticky status bits, level threshold and interrupt line.
// Assumes the occupancy input is the live FIFO count.
module afc_status
    import afc_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic [3:0]       lvl_i,
    input  logic             irq_en_i,
    input  logic [ST_W-1:0]  mask_i,
    input  logic [ST_W-1:0]  clr_i,
    output logic [ST_W-1:0]  status_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] thresh;
    logic [ST_W-1:0]  cond;

    // Live conditions: empty, and below the power-of-two threshold.
    always_comb begin
        thresh         = CNT_W'(DEPTH) >> lvl_i;
        cond[ST_UNDER] = (count_i == '0);
        cond[ST_LEVEL] = (count_i < thresh);
    end

    for (genvar i = 0; i < ST_W; i++) begin : g_bit
        // One sticky bit: clear has priority, then the condition sets it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                status_o[i] <= 1'b0;
            else if (clr_i[i])
                status_o[i] <= 1'b0;
            else if (cond[i])
                status_o[i] <= 1'b1;
        end

        a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i[i] |=> !status_o[i]);
    end

    assign irq_o = irq_en_i && |(status_o & mask_i);

    a_r6_underrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i == '0 && !clr_i[ST_UNDER]) |=> status_o[ST_UNDER]);
endmodule

// File: rtl/afc_ctrl.sv
// Top level: register block, sample FIFO and status/interrupt logic.
// Assumes DEPTH is a power of two; serializer pops through smp_valid/smp_ready.
module afc_ctrl
    import afc_pkg::*;
#(
    parameter int                DEPTH   = 1024,
    parameter logic [WORD_W-1:0] VERSION = 32'h0001_0000,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [2:0]  bus_word,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        smp_valid,
    input  logic        smp_ready,
    output logic [31:0] smp_data,
    output logic        irq,
    output logic        cfg_tx_en,
    output logic        cfg_left,
    output logic [7:0]  cfg_ratio,
    output logic [5:0]  cfg_res,
    output logic [3:0]  cfg_chan
);
    cfg_t             cfg;
    logic [ST_W-1:0]  mask, clr, status;
    logic             push;
    logic [31:0]      push_data;
    logic [CNT_W-1:0] count;

    afc_regs #(.VERSION(VERSION)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .status_i(status), .cfg_o(cfg), .mask_o(mask), .clr_o(clr),
        .push_o(push), .push_data_o(push_data)
    );

    afc_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(push), .push_data_i(push_data),
        .valid_o(smp_valid), .ready_i(smp_ready), .data_o(smp_data),
        .count_o(count)
    );

    afc_status #(.DEPTH(DEPTH)) u_status (
        .clk(clk), .rst_n(rst_n),
        .count_i(count), .lvl_i(cfg.lvl), .irq_en_i(cfg.irq_en),
        .mask_i(mask), .clr_i(clr), .status_o(status), .irq_o(irq)
    );

    assign cfg_tx_en = cfg.tx_en;
    assign cfg_left  = cfg.left;
    assign cfg_ratio = cfg.ratio;
    assign cfg_res   = cfg.res;
    assign cfg_chan  = cfg.chan;
endmodule

// File: tb/afc_ctrl_bench.sv
module afc_ctrl_bench;
    localparam int          DEPTH = 16;
    localparam logic [31:0] VER   = 32'h0001_0203;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, smp_ready = 1'b0;
    logic [2:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, smp_data;
    logic        smp_valid, irq, cfg_tx_en, cfg_left;
    logic [7:0]  cfg_ratio;
    logic [5:0]  cfg_res;
    logic [3:0]  cfg_chan;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    afc_ctrl #(.DEPTH(DEPTH), .VERSION(VER)) u_afc_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
        .irq(irq), .cfg_tx_en(cfg_tx_en), .cfg_left(cfg_left),
        .cfg_ratio(cfg_ratio), .cfg_res(cfg_res), .cfg_chan(cfg_chan)
    );

    // Vector: {is_read, word, wdata, expected read data}
    localparam int NV = 15;
    localparam logic [67:0] VEC [NV] = '{
        {1'b1, 3'd0, 32'h0,         VER},           // R1 version
        {1'b1, 3'd1, 32'h0,         32'h0},         // R9 config reset
        {1'b1, 3'd2, 32'h0,         32'h0},         // R9 mask reset
        {1'b0, 3'd2, 32'hFFFF_FFFC, 32'h0},
        {1'b1, 3'd2, 32'h0,         32'h0},         // R3 upper bits dropped
        {1'b0, 3'd1, 32'hFFFF_FFFF, 32'h0},
        {1'b1, 3'd1, 32'h0,         32'hFF3F_FF07}, // R2 field mask
        {1'b0, 3'd0, 32'h1234_5678, 32'h0},
        {1'b1, 3'd0, 32'h0,         VER},           // R1 write ignored
        {1'b1, 3'd4, 32'h0,         32'h0},         // R1 data port write-only
        {1'b1, 3'd3, 32'h0,         32'h3},         // R5 sticky level from earlier
        {1'b0, 3'd3, 32'h3,         32'h0},
        {1'b1, 3'd3, 32'h0,         32'h0},         // R5 cleared
        {1'b1, 3'd3, 32'h0,         32'h1},         // R6 underrun back, code 15 no level
        {1'b0, 3'd1, 32'h0,         32'h0}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Each access occupies one clock edge; called at a falling edge.
    task automatic wr(input logic [2:0] w, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_word = w; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] w, input logic [31:0] exp, input string tag);
        bus_sel = 1; bus_wr = 0; bus_word = w;
        @(negedge clk);
        bus_sel = 0;
        check(tag, bus_rdata, exp);
    endtask

    task automatic pop(input logic [31:0] exp, input string tag);
        check(tag, {31'b0, smp_valid}, 32'h1);
        check(tag, smp_data, exp);
        smp_ready = 1;
        @(negedge clk);
        smp_ready = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset state at the ports
        check("R9 irq", {31'b0, irq}, 0);
        check("R9 valid", {31'b0, smp_valid}, 0);
        check("R9 rdata", bus_rdata, 0);
        check("R9 cfg", {cfg_chan, cfg_res, cfg_ratio, cfg_left, cfg_tx_en}, 0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][67]) rd(VEC[i][66:64], VEC[i][31:0], $sformatf("vector %0d", i));
            else            wr(VEC[i][66:64], VEC[i][63:32]);
        end

        // R4 alias ports, order of left then right
        wr(3'd4, 32'hAAAA_0001);
        wr(3'd5, 32'hBBBB_0002);
        pop(32'hAAAA_0001, "R4 left");
        pop(32'hBBBB_0002, "R4 right");
        check("R4 empty", {31'b0, smp_valid}, 0);

        // R7 overflow drop; R11 hold of read data not disturbed by writes
        for (int i = 0; i < DEPTH + 2; i++) wr(3'd4, 32'h100 + i);
        check("R11 rdata held", bus_rdata, 32'h1);
        for (int i = 0; i < DEPTH; i++) pop(32'h100 + i, "R7 contents");
        check("R7 extra dropped", {31'b0, smp_valid}, 0);

        // R6 threshold with code 2 -> 4 words
        wr(3'd1, 32'h0200_0000);
        for (int i = 0; i < 4; i++) wr(3'd6, 32'h200 + i);
        wr(3'd3, 32'h3);
        rd(3'd3, 32'h0, "R5 read after clear");
        rd(3'd3, 32'h0, "R6 at threshold");
        pop(32'h200, "R6 pop");
        @(negedge clk);
        rd(3'd3, 32'h2, "R6 below threshold");
        for (int i = 1; i < 4; i++) pop(32'h200 + i, "R6 drain");
        @(negedge clk);
        rd(3'd3, 32'h3, "R6 empty");

        // R8 interrupt gating
        wr(3'd2, 32'h2);
        check("R8 enable off", {31'b0, irq}, 0);
        wr(3'd1, 32'h0200_0002);
        check("R8 enabled level", {31'b0, irq}, 1);
        wr(3'd2, 32'h0);
        check("R8 all masked", {31'b0, irq}, 0);
        wr(3'd2, 32'h1);
        check("R8 underrun", {31'b0, irq}, 1);
        for (int i = 0; i < 8; i++) wr(3'd7, 32'h300 + i);
        wr(3'd3, 32'h3);
        check("R8 cleared", {31'b0, irq}, 0);
        @(negedge clk);
        check("R8 stays low", {31'b0, irq}, 0);
        for (int i = 0; i < 8; i++) pop(32'h300 + i, "R4 drain");

        // R10 config outputs
        wr(3'd1, 32'h1418_5A05);
        check("R10 tx_en", {31'b0, cfg_tx_en}, 1);
        check("R10 left", {31'b0, cfg_left}, 1);
        check("R10 ratio", {24'b0, cfg_ratio}, 32'h5A);
        check("R10 res", {26'b0, cfg_res}, 32'h18);
        check("R10 chan", {28'b0, cfg_chan}, 32'h1);
        rd(3'd1, 32'h1418_5A05, "R2 readback");

        finish_run();
    end
endmodule